// File: doc/BRIEF.md
# Nine-Word Pipelined Carry-Save Summer

This block adds nine unsigned W-bit words presented together on one clock and returns their exact total as a single (W+4)-bit word. The words pass through four registered layers of 3:2 carry-save compressors. The layers reduce nine words to six, then to four, then to three, and finally to two. In the third layer, one word skips compression and is only registered, so it reaches the last compressor together with the other two words. A registered carry-propagate adder then merges the last two words.

Every layer is a pipeline stage, so a new set of nine words can enter on every clock. A valid flag travels with each set through all five registers. The result appears a fixed five cycles after the set is accepted. A cycle with the input flag low enters no set and changes no stored data. Typical uses are checksum accumulation, dot-product reduction and sums of multiplier partial products, wherever a wide sum is needed at full clock rate.

Top module: `csa9_sum_pipe`

## Requirements
- R1: When out_vld is high, out_sum equals the exact unsigned sum of the nine W-bit words in the set it belongs to. Word k occupies in_words bits [k*W +: W].
- R2: A set accepted on a rising edge with in_vld high appears with out_vld high exactly five rising edges later (four compression layers plus one adder stage).
- R3: Sets presented on consecutive cycles produce results on consecutive cycles, in the same order, with no bubbles.
- R4: In a cycle where in_vld is low, the value on in_words has no effect on any later output, and no result is produced for that cycle.
- R5: While rst is high at a rising edge, out_vld and out_sum are cleared to 0.
- R6: Nine all-ones words give 9*(2^W-1) with no wrap-around. No result ever exceeds that value.
- R7: The tree reduces 9 to 6 to 4 to 3 to 2 words. Each layer keeps the word total (modulo 2^(W+4)) unchanged, and the fourth word of the third layer passes through as a register only.
- R8: A reset while sets are in flight discards all of them. No result appears until a new set has had its full latency.
- R9: In cycles without a new result, out_sum holds the most recent result (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies in_words on this cycle |
| in_words | input | 9*W | Nine packed unsigned words, word k at bits [k*W +: W] |
| out_vld | output | 1 | High for one cycle per finished set |
| out_sum | output | W+4 | Registered sum of the set |

## Verification
The layer and top assertions assume that in_vld is a known 0 or 1 after reset, and that a set is fully captured on the edge where in_vld is sampled high. The sum-preservation check compares a layer's output total with the total it sampled one cycle earlier, so it relies on in_words being stable around the edge. The stimulus changes the inputs only at the falling edge and always drives in_vld to a defined level. During idle cycles it puts random junk on in_words, so that the ignore behaviour is exercised without breaking those assumptions.

// File: rtl/csa9_pkg.sv
package csa9_pkg;
  localparam int NWORDS = 9;
  localparam int GROWTH = 4;

  // words leaving a layer of 3:2 compressors plus pass-through leftovers
  function automatic int layer_out(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction
endpackage

// File: rtl/csa_cell.sv
module csa_cell #(
  parameter int WD = 20
) (
  input  logic [WD-1:0] a,
  input  logic [WD-1:0] b,
  input  logic [WD-1:0] c,
  output logic [WD-1:0] s,
  output logic [WD-1:0] k
);
  logic [WD-1:0] maj;

  always_comb begin
    s   = a ^ b ^ c;
    maj = (a & b) | (a & c) | (b & c);
    k   = {maj[WD-2:0], 1'b0};
  end
endmodule

// File: rtl/csa_layer.sv
module csa_layer #(
  parameter int WD  = 20,
  parameter int NIN = 9
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_vld,
  input  logic [NIN*WD-1:0]                      in_bus,
  output logic                                   out_vld,
  output logic [csa9_pkg::layer_out(NIN)*WD-1:0] out_bus
);
  localparam int NCSA  = NIN / 3;
  localparam int NPASS = NIN % 3;
  localparam int NOUT  = csa9_pkg::layer_out(NIN);

  logic [NOUT*WD-1:0] nxt;

  for (genvar g = 0; g < NCSA; g++) begin : g_csa
    csa_cell #(.WD(WD)) u_cell (
      .a(in_bus[(3*g)*WD +: WD]),
      .b(in_bus[(3*g+1)*WD +: WD]),
      .c(in_bus[(3*g+2)*WD +: WD]),
      .s(nxt[(2*g)*WD +: WD]),
      .k(nxt[(2*g+1)*WD +: WD])
    );
  end

  for (genvar p = 0; p < NPASS; p++) begin : g_pass
    assign nxt[(2*NCSA+p)*WD +: WD] = in_bus[(3*NCSA+p)*WD +: WD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_bus <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_bus <= nxt;
    end
  end

  function automatic logic [WD-1:0] total_in(input logic [NIN*WD-1:0] v);
    logic [WD-1:0] t = '0;
    for (int i = 0; i < NIN; i++) t += v[i*WD +: WD];
    return t;
  endfunction

  function automatic logic [WD-1:0] total_out(input logic [NOUT*WD-1:0] v);
    logic [WD-1:0] t = '0;
    for (int i = 0; i < NOUT; i++) t += v[i*WD +: WD];
    return t;
  endfunction

  // R7: a layer never changes the word total of the set it carries
  assert_sum_kept_R7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (total_out(out_bus) == $past(total_in(in_bus))));

  // R4: flag flows one stage per edge
  assert_vld_follows_R4: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
endmodule

// File: rtl/cpa_stage.sv
module cpa_stage #(
  parameter int WD = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [2*WD-1:0] in_bus,
  output logic          out_vld,
  output logic [WD-1:0] out_sum
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sum <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_sum <= in_bus[0 +: WD] + in_bus[WD +: WD];
    end
  end
endmodule

// File: rtl/csa9_sum_pipe.sv
module csa9_sum_pipe #(
  parameter int W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_vld,
  input  logic [csa9_pkg::NWORDS*W-1:0]  in_words,
  output logic                           out_vld,
  output logic [W+csa9_pkg::GROWTH-1:0]  out_sum
);
  import csa9_pkg::*;

  localparam int OW = W + GROWTH;
  localparam int N1 = layer_out(NWORDS);
  localparam int N2 = layer_out(N1);
  localparam int N3 = layer_out(N2);
  localparam int N4 = layer_out(N3);
  localparam logic [OW-1:0] PEAK = OW'(NWORDS) * OW'((1 << W) - 1);

  logic [NWORDS*OW-1:0] l0;
  logic [N1*OW-1:0] l1;
  logic [N2*OW-1:0] l2;
  logic [N3*OW-1:0] l3;
  logic [N4*OW-1:0] l4;
  logic v1, v2, v3, v4;
  logic armed;

  for (genvar i = 0; i < NWORDS; i++) begin : g_ext
    assign l0[i*OW +: OW] = {{GROWTH{1'b0}}, in_words[i*W +: W]};
  end

  csa_layer #(.WD(OW), .NIN(NWORDS)) u_lay1 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bus(l0), .out_vld(v1), .out_bus(l1));
  csa_layer #(.WD(OW), .NIN(N1)) u_lay2 (
    .clk(clk), .rst(rst), .in_vld(v1), .in_bus(l1), .out_vld(v2), .out_bus(l2));
  csa_layer #(.WD(OW), .NIN(N2)) u_lay3 (
    .clk(clk), .rst(rst), .in_vld(v2), .in_bus(l2), .out_vld(v3), .out_bus(l3));
  csa_layer #(.WD(OW), .NIN(N3)) u_lay4 (
    .clk(clk), .rst(rst), .in_vld(v3), .in_bus(l3), .out_vld(v4), .out_bus(l4));

  cpa_stage #(.WD(OW)) u_cpa (
    .clk(clk), .rst(rst), .in_vld(v4), .in_bus(l4), .out_vld(out_vld), .out_sum(out_sum));

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R6: result never wraps past the largest nine-word total
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_sum <= PEAK));

  // R2: every result traces back to an accepted set five edges earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld, 5));

  // R9: output word is held between results
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_vld) |-> $stable(out_sum));

  // R7: schedule reaches two words after four layers
  initial begin
    assert_schedule_R7: assert (N1 == 6 && N2 == 4 && N3 == 3 && N4 == 2);
  end
endmodule

// File: tb/tb_csa9_sum_pipe.sv
module tb_csa9_sum_pipe;
  localparam int W = 16;
  localparam int OW = W + 4;
  localparam int LAT = 5;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [9*W-1:0] in_words = '0;
  logic out_vld;
  logic [OW-1:0] out_sum;

  csa9_sum_pipe #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_words(in_words),
    .out_vld(out_vld), .out_sum(out_sum));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R5";

  // behavioural reference: a delay line of (valid, total) pairs
  bit      mv [LAT];
  longint  ms [LAT];
  longint  last = 0;

  initial for (int i = 0; i < LAT; i++) begin mv[i] = 0; ms[i] = 0; end

  function automatic longint words_total(input logic [9*W-1:0] v);
    longint t = 0;
    for (int i = 0; i < 9; i++) t += longint'(v[i*W +: W]);
    return t;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin mv[i] = 0; ms[i] = 0; end
      last = 0;
    end else begin
      for (int i = LAT-1; i > 0; i--) begin mv[i] = mv[i-1]; ms[i] = ms[i-1]; end
      mv[0] = in_vld;
      ms[0] = words_total(in_words);
      if (mv[LAT-1]) last = ms[LAT-1];
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    checks++;
    if (out_vld !== mv[LAT-1] || out_sum !== OW'(last)) begin
      fails++;
      $display("FAIL %s: out_vld=%0b exp %0b out_sum=%0d exp %0d",
               cur_req, out_vld, mv[LAT-1], out_sum, last);
    end
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d exp below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // kind 0 random, 1 all ones, 2 zeros
  task automatic drive(input bit v, input int kind);
    @(negedge clk);
    in_vld = v;
    for (int i = 0; i < 9; i++)
      case (kind)
        1: in_words[i*W +: W] = '1;
        2: in_words[i*W +: W] = '0;
        default: in_words[i*W +: W] = W'($urandom);
      endcase
  endtask

  initial begin
    cur_req = "R5";                       // reset clears outputs
    repeat (4) drive(0, 0);
    @(negedge clk); rst = 1'b0;

    cur_req = "R1";                       // random sets, sparse
    for (int n = 0; n < 20; n++) begin drive(1, 0); drive(0, 0); end
    repeat (LAT + 1) drive(0, 0);

    cur_req = "R2";                       // single set, fixed five-cycle latency
    drive(1, 0);
    repeat (LAT + 2) drive(0, 0);

    cur_req = "R6";                       // all-ones peak, zeros floor
    repeat (3) drive(1, 1);
    drive(1, 2);
    drive(1, 1);
    repeat (LAT + 1) drive(0, 0);

    cur_req = "R3";                       // back-to-back stream
    for (int n = 0; n < 200; n++) drive(1, 0);
    repeat (LAT + 1) drive(0, 0);

    cur_req = "R4";                       // junk with valid low is ignored
    drive(1, 0);
    for (int n = 0; n < 30; n++) drive(0, 1);

    cur_req = "R9";                       // result held across idle cycles
    for (int n = 0; n < 10; n++) begin drive(1, 0); repeat (3) drive(0, 0); end
    repeat (LAT + 1) drive(0, 0);

    cur_req = "R8";                       // reset with sets in flight
    repeat (4) drive(1, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; in_vld = 1'b0;
    repeat (LAT + 2) drive(0, 0);
    drive(1, 0);
    repeat (LAT + 1) drive(0, 0);

    cur_req = "R7";                       // mixed pattern through the schedule
    for (int n = 0; n < 60; n++) drive(1, n % 3);
    repeat (LAT + 1) drive(0, 0);

    finish_run();
  end
endmodule